// File: doc/BRIEF.md
# Audio FIFO Glue Controller

This block is a byte-wide, register-mapped front end placed between a host bus and a low-rate telephone-quality codec. It holds three byte queues. A playback queue carries samples from the host to the codec. A record queue carries samples from the codec to the host. A write-only command queue carries command bytes to the codec command port. The host reaches all of this through six register offsets, selected with a single select strobe and a read/write flag.

The codec side is modelled as a plain byte sink and byte source. On each sample strobe it takes one playback byte and offers one record byte, but only while the data path is connected. The command queue fills silently until the host connects it. It then drains one byte per clock until it is empty.

Four level events follow queue occupancy: playback empty, command empty, playback at or below half, and record at or above half. Each event has an enable bit four positions above it. The OR of the enabled events forms a request bit. That request, gated by a master enable, drives the single interrupt output.

Top module: `audio_fifo_glue`

## Requirements
- R1: After reset, the control register reads 0x00, the interrupt register reads 0x0E, the status register reads 0x15 and `irq` is low.
- R2: Offset 0 reads the `ID_VALUE` parameter (default 0xA5). A write to offset 0 empties all three queues and clears every control and enable bit.
- R3: The playback queue holds `DATA_DEPTH` bytes (default 128). A host write to offset 4 while the queue is full is dropped.
- R4: A host read of offset 4 while the record queue is empty returns 0x00 and changes no state.
- R5: While control bit 2 is clear, bytes written to offset 5 only accumulate. While the bit is set, the command queue presents one byte per clock on `cmd_byte`/`cmd_valid`, in write order, until it is empty.
- R6: While control bit 0 is set, each `smp_strobe` pops one playback byte onto `cdc_out_byte` with `cdc_out_valid` high and pushes `cdc_in_byte` into the record queue, unless that queue is full. While bit 0 is clear, the strobe has no effect.
- R7: Offset 2 reads the enables in bits 7:4 and the events in bits 3:0: playback empty (bit 3), command empty (bit 2), playback count at most `HALF_MARK` (bit 1), and record count at least `HALF_MARK` (bit 0, default mark 64). Writes change only bits 7:4.
- R8: Control bit 6 is read-only and equals the OR of the events whose enables are set. `irq` equals bit 6 AND control bit 7.
- R9: Offset 3 is read-only. Its bits 5 down to 0 are: command full, command empty, playback full, playback empty, record full, record empty.
- R10: Both data queues deliver bytes in the order they were written.
- R11: Control bits 7, 3, 2 and 0 are writable and read back as written. Bits 5, 4 and 1 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access strobe, one access per clock |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid in the same cycle as the access |
| smp_strobe | input | 1 | Codec sample strobe |
| cdc_in_byte | input | 8 | Byte offered by the codec on a strobe |
| cdc_out_byte | output | 8 | Playback byte handed to the codec |
| cdc_out_valid | output | 1 | Playback byte is taken in this cycle |
| cmd_byte | output | 8 | Command byte to the codec command port |
| cmd_valid | output | 1 | Command byte is taken in this cycle |
| irq | output | 1 | Interrupt request |

## Verification
The half-mark events are the hardest part to reach. They change only after dozens of bytes have moved, and each one flips on a single count: 65 versus 64 in the playback queue, and 63 versus 64 in the record queue. The stimulus first fills the playback queue to its limit with data disconnected. It then connects the data path and issues strobes one at a time, so that the playback queue drains while the record queue fills. The interrupt register is read exactly at strobes 63 and 64. Later, host reads take the full record queue down across the mark again, and `irq` is watched on either side of it.

// File: rtl/afg_pkg.sv
package afg_pkg;
   // register offsets (host view)
   localparam logic [2:0] OFS_ID     = 3'd0;
   localparam logic [2:0] OFS_CTRL   = 3'd1;
   localparam logic [2:0] OFS_EVT    = 3'd2;
   localparam logic [2:0] OFS_STAT   = 3'd3;
   localparam logic [2:0] OFS_DATA   = 3'd4;
   localparam logic [2:0] OFS_CMD    = 3'd5;

   // control register bit positions
   localparam int CB_IE   = 7;
   localparam int CB_REQ  = 6;
   localparam int CB_W16  = 3;
   localparam int CB_CEN  = 2;
   localparam int CB_DEN  = 0;

   // event indices; enable of event i sits at bit i+4
   localparam int EV_HALF_IN   = 0;
   localparam int EV_HALF_OUT  = 1;
   localparam int EV_CMD_EMPTY = 2;
   localparam int EV_OUT_EMPTY = 3;
   localparam int NUM_EV       = 4;

   typedef struct packed {
      logic ie;
      logic w16;
      logic cen;
      logic den;
   } ctrl_t;
endpackage

// File: rtl/afg_fifo.sv
module afg_fifo #(
   parameter int DEPTH = 128,
   parameter int WIDTH = 8,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic [CW-1:0]    count,
   output logic             full,
   output logic             empty
);
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
   localparam logic [AW-1:0] LAST_C  = AW'(DEPTH - 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("afg_fifo: DEPTH must be at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic             do_push, do_pop;

   assign full    = (count == DEPTH_C);
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rd_ptr];

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap
      assign wr_nxt = (wr_ptr == LAST_C) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == LAST_C) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/afg_events.sv
module afg_events #(
   parameter int DEPTH     = 128,
   parameter int HALF_MARK = 64,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          out_empty,
   input  logic          cmd_empty,
   input  logic [CW-1:0] out_count,
   input  logic [CW-1:0] in_count,
   input  logic [3:0]    enables,
   output logic [3:0]    events,
   output logic          request
);
   import afg_pkg::*;
   localparam logic [CW-1:0] MARK_C = CW'(HALF_MARK);

   logic [NUM_EV-1:0] armed;

   always_comb begin
      events               = '0;
      events[EV_OUT_EMPTY] = out_empty;
      events[EV_CMD_EMPTY] = cmd_empty;
      events[EV_HALF_OUT]  = (out_count <= MARK_C);
      events[EV_HALF_IN]   = (in_count >= MARK_C);
   end

   for (genvar i = 0; i < NUM_EV; i++) begin : g_arm
      assign armed[i] = events[i] & enables[i];
   end

   assign request = |armed;
endmodule

// File: rtl/audio_fifo_glue.sv
module audio_fifo_glue #(
   parameter int         DATA_DEPTH = 128,
   parameter int         CMD_DEPTH  = 16,
   parameter int         HALF_MARK  = DATA_DEPTH / 2,
   parameter logic [7:0] ID_VALUE   = 8'hA5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       host_sel,
   input  logic       host_wr,
   input  logic [2:0] host_addr,
   input  logic [7:0] host_wdata,
   output logic [7:0] host_rdata,
   input  logic       smp_strobe,
   input  logic [7:0] cdc_in_byte,
   output logic [7:0] cdc_out_byte,
   output logic       cdc_out_valid,
   output logic [7:0] cmd_byte,
   output logic       cmd_valid,
   output logic       irq
);
   import afg_pkg::*;
   localparam int DCW = $clog2(DATA_DEPTH + 1);
   localparam int CCW = $clog2(CMD_DEPTH + 1);

   if (HALF_MARK < 1 || HALF_MARK >= DATA_DEPTH) begin : g_bad_mark
      $error("audio_fifo_glue: HALF_MARK must lie inside the data queue");
   end

   logic        wr_hit, rd_hit, soft_rst;
   ctrl_t       ctrl_q;
   logic [3:0]  en_q;
   logic [3:0]  events;
   logic        request;

   logic [7:0]     out_head, in_head, cmd_head;
   logic [DCW-1:0] out_count, in_count;
   logic [CCW-1:0] cmd_count;
   logic           out_full, out_empty, in_full, in_empty, cmd_full, cmd_empty;
   logic           data_step;

   assign wr_hit    = host_sel && host_wr;
   assign rd_hit    = host_sel && !host_wr;
   assign soft_rst  = wr_hit && (host_addr == OFS_ID);
   assign data_step = smp_strobe && ctrl_q.den;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         en_q   <= '0;
      end else if (soft_rst) begin
         ctrl_q <= '0;
         en_q   <= '0;
      end else if (wr_hit) begin
         if (host_addr == OFS_CTRL) begin
            ctrl_q.ie  <= host_wdata[CB_IE];
            ctrl_q.w16 <= host_wdata[CB_W16];
            ctrl_q.cen <= host_wdata[CB_CEN];
            ctrl_q.den <= host_wdata[CB_DEN];
         end
         if (host_addr == OFS_EVT) en_q <= host_wdata[7:4];
      end
   end

   afg_fifo #(.DEPTH(DATA_DEPTH), .WIDTH(8)) u_out_q (
      .clk(clk), .rst_n(rst_n), .flush(soft_rst),
      .push(wr_hit && host_addr == OFS_DATA), .wdata(host_wdata),
      .pop(data_step), .head(out_head), .count(out_count),
      .full(out_full), .empty(out_empty));

   afg_fifo #(.DEPTH(DATA_DEPTH), .WIDTH(8)) u_in_q (
      .clk(clk), .rst_n(rst_n), .flush(soft_rst),
      .push(data_step), .wdata(cdc_in_byte),
      .pop(rd_hit && host_addr == OFS_DATA), .head(in_head), .count(in_count),
      .full(in_full), .empty(in_empty));

   afg_fifo #(.DEPTH(CMD_DEPTH), .WIDTH(8)) u_cmd_q (
      .clk(clk), .rst_n(rst_n), .flush(soft_rst),
      .push(wr_hit && host_addr == OFS_CMD), .wdata(host_wdata),
      .pop(cmd_valid), .head(cmd_head), .count(cmd_count),
      .full(cmd_full), .empty(cmd_empty));

   afg_events #(.DEPTH(DATA_DEPTH), .HALF_MARK(HALF_MARK)) u_events (
      .out_empty(out_empty), .cmd_empty(cmd_empty),
      .out_count(out_count), .in_count(in_count),
      .enables(en_q), .events(events), .request(request));

   assign cmd_valid     = ctrl_q.cen && !cmd_empty;
   assign cmd_byte      = cmd_head;
   assign cdc_out_valid = data_step && !out_empty;
   assign cdc_out_byte  = out_head;
   assign irq           = request && ctrl_q.ie;

   always_comb begin
      host_rdata = 8'h00;
      case (host_addr)
         OFS_ID:   host_rdata = ID_VALUE;
         OFS_CTRL: begin
            host_rdata[CB_IE]  = ctrl_q.ie;
            host_rdata[CB_REQ] = request;
            host_rdata[CB_W16] = ctrl_q.w16;
            host_rdata[CB_CEN] = ctrl_q.cen;
            host_rdata[CB_DEN] = ctrl_q.den;
         end
         OFS_EVT:  host_rdata = {en_q, events};
         OFS_STAT: host_rdata = {2'b00, cmd_full, cmd_empty, out_full, out_empty,
                                 in_full, in_empty};
         OFS_DATA: host_rdata = in_empty ? 8'h00 : in_head;
         default:  host_rdata = 8'h00;
      endcase
   end
endmodule

// File: rtl/afg_checker.sv
module afg_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       host_sel,
   input logic       host_wr,
   input logic [2:0] host_addr,
   input logic [7:0] host_rdata,
   input logic       smp_strobe,
   input logic       cdc_out_valid,
   input logic       cmd_valid,
   input logic       irq,
   input logic       ie,
   input logic       cen,
   input logic       den,
   input logic       request,
   input logic       out_full,
   input logic       out_empty,
   input logic       in_empty
);
   assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ie && request));

   assert_cmd_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> cen);

   assert_out_only_on_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cdc_out_valid |-> (smp_strobe && den));

   assert_full_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_full && !(smp_strobe && den)) |=> out_full);

   assert_empty_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (host_sel && !host_wr && host_addr == 3'd4 && in_empty) |-> (host_rdata == 8'h00));

   assert_empty_read_stays_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (host_sel && !host_wr && host_addr == 3'd4 && in_empty && !(smp_strobe && den))
      |=> in_empty);

   assert_soft_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_sel && host_wr && host_addr == 3'd0) |=> (!ie && !cen && !den && out_empty && !irq));
endmodule

bind audio_fifo_glue afg_checker u_afg_checker (
   .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
   .host_addr(host_addr), .host_rdata(host_rdata), .smp_strobe(smp_strobe),
   .cdc_out_valid(cdc_out_valid), .cmd_valid(cmd_valid), .irq(irq),
   .ie(ctrl_q.ie), .cen(ctrl_q.cen), .den(ctrl_q.den), .request(request),
   .out_full(out_full), .out_empty(out_empty), .in_empty(in_empty));

// File: tb/audio_fifo_glue_bench.sv
module audio_fifo_glue_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_sel = 1'b0, host_wr = 1'b0;
   logic [2:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       smp_strobe = 1'b0;
   logic [7:0] cdc_in_byte = '0;
   logic [7:0] cdc_out_byte, cmd_byte;
   logic       cdc_out_valid, cmd_valid, irq;

   int checks = 0, failures = 0, cmd_seen = 0;
   bit done = 1'b0;
   logic [7:0] exp_out[$];
   logic [7:0] exp_cmd[$];
   logic [7:0] exp_in[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   audio_fifo_glue u_audio_fifo_glue (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .smp_strobe(smp_strobe), .cdc_in_byte(cdc_in_byte),
      .cdc_out_byte(cdc_out_byte), .cdc_out_valid(cdc_out_valid),
      .cmd_byte(cmd_byte), .cmd_valid(cmd_valid), .irq(irq));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus(input bit wr, input logic [2:0] a, input logic [7:0] d,
                      output logic [7:0] rd);
      @(negedge clk);
      host_sel = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
      #1 rd = host_rdata;
      @(posedge clk);
      #1 host_sel = 1'b0; host_wr = 1'b0;
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
      logic [7:0] unused;
      bus(1'b1, a, d, unused);
   endtask

   task automatic rd_expect(input logic [2:0] a, input logic [7:0] e, input string req);
      logic [7:0] v;
      bus(1'b0, a, 8'h00, v);
      chk(v === e, req, v, e);
   endtask

   task automatic strobe(input logic [7:0] inb, output bit valid);
      @(negedge clk);
      smp_strobe = 1'b1; cdc_in_byte = inb;
      #1 valid = cdc_out_valid;
      @(posedge clk);
      #1 smp_strobe = 1'b0;
   endtask

   // monitor: compares codec-side output against the scoreboard queues
   always begin
      @(negedge clk);
      #2;
      if (rst_n && !done) begin
         if (cmd_valid) begin
            cmd_seen++;
            if (exp_cmd.size() == 0) chk(1'b0, "R5 unexpected cmd", cmd_byte, 0);
            else begin
               logic [7:0] e;
               e = exp_cmd.pop_front();
               chk(cmd_byte === e, "R5 cmd order", cmd_byte, e);
            end
         end
         if (cdc_out_valid) begin
            if (exp_out.size() == 0) chk(1'b0, "R6 unexpected out", cdc_out_byte, 0);
            else begin
               logic [7:0] e;
               e = exp_out.pop_front();
               chk(cdc_out_byte === e, "R10 playback order", cdc_out_byte, e);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++; checks++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      bit v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd_expect(3'd1, 8'h00, "R1 ctrl");
      rd_expect(3'd2, 8'h0E, "R1 evt");
      rd_expect(3'd3, 8'h15, "R1 stat");
      chk(irq === 1'b0, "R1 irq", irq, 0);
      rd_expect(3'd0, 8'hA5, "R2 id");

      // R5 command queue accumulates, then drains in order
      for (int i = 0; i < 3; i++) begin
         exp_cmd.push_back(8'h30 + 8'(i));
         wr_reg(3'd5, 8'h30 + 8'(i));
      end
      repeat (4) @(posedge clk);
      chk(cmd_seen == 0, "R5 held while disabled", cmd_seen, 0);
      rd_expect(3'd3, 8'h05, "R9 cmd not empty");
      wr_reg(3'd1, 8'h04);
      repeat (6) @(posedge clk);
      chk(cmd_seen == 3, "R5 drained", cmd_seen, 3);
      rd_expect(3'd3, 8'h15, "R5 cmd empty");
      rd_expect(3'd1, 8'h04, "R11 cen readback");
      wr_reg(3'd1, 8'h00);

      // R3 fill playback queue, overflow dropped
      for (int i = 0; i < 128; i++) begin
         exp_out.push_back(8'(i) ^ 8'h3C);
         wr_reg(3'd4, 8'(i) ^ 8'h3C);
      end
      rd_expect(3'd3, 8'h19, "R9 out full");
      rd_expect(3'd2, 8'h04, "R7 full events");
      wr_reg(3'd4, 8'hEE);
      strobe(8'h77, v);
      chk(v == 1'b0, "R6 strobe ignored when disconnected", v, 0);
      rd_expect(3'd3, 8'h19, "R6 no record push");

      // R6/R7 connect data path, drain and fill across the mark
      wr_reg(3'd1, 8'h01);
      for (int i = 0; i < 128; i++) begin
         exp_in.push_back(8'(i + 1));
         strobe(8'(i + 1), v);
         if (i == 62) rd_expect(3'd2, 8'h04, "R7 65 out / 63 in");
         if (i == 63) rd_expect(3'd2, 8'h07, "R7 64 out / 64 in");
      end
      chk(exp_out.size() == 0, "R3 overflow byte absent", exp_out.size(), 0);
      rd_expect(3'd3, 8'h16, "R9 out empty in full");
      strobe(8'h99, v);
      chk(v == 1'b0, "R6 no byte when empty", v, 0);

      // R8 request and irq
      wr_reg(3'd2, 8'h1F);
      rd_expect(3'd2, 8'h1F, "R7 enable write");
      rd_expect(3'd1, 8'h41, "R8 request bit");
      chk(irq === 1'b0, "R8 irq gated", irq, 0);
      wr_reg(3'd1, 8'h80);
      #1 chk(irq === 1'b1, "R8 irq high", irq, 1);
      rd_expect(3'd1, 8'hC0, "R8 ctrl with request");

      // R10 record order, irq drops below mark
      for (int i = 0; i < 128; i++) begin
         logic [7:0] r, e;
         bus(1'b0, 3'd4, 8'h00, r);
         e = exp_in.pop_front();
         if (i < 3 || i > 124 || r !== e) chk(r === e, "R10 record order", r, e);
         if (i == 63) chk(irq === 1'b1, "R8 irq at 64", irq, 1);
         if (i == 64) chk(irq === 1'b0, "R8 irq at 63", irq, 0);
      end
      rd_expect(3'd4, 8'h00, "R4 empty read");
      rd_expect(3'd3, 8'h15, "R4 state unchanged");
      wr_reg(3'd1, 8'hC0);
      rd_expect(3'd1, 8'h80, "R8 request read-only");
      wr_reg(3'd1, 8'h3A);
      rd_expect(3'd1, 8'h08, "R11 writable bits");

      // R2 soft reset
      wr_reg(3'd4, 8'h11);
      wr_reg(3'd5, 8'h22);
      wr_reg(3'd2, 8'hF0);
      wr_reg(3'd1, 8'h88);
      wr_reg(3'd0, 8'h00);
      rd_expect(3'd1, 8'h00, "R2 ctrl cleared");
      rd_expect(3'd2, 8'h0E, "R2 enables cleared");
      rd_expect(3'd3, 8'h15, "R2 queues emptied");
      chk(irq === 1'b0, "R2 irq", irq, 0);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule